// File: doc/BRIEF.md
# Multiplexed External Bus Strobe Generator

This block produces the external memory bus timing for an 8-bit single-chip controller. It runs on the oscillator clock. A machine cycle is 12 clocks: six states of two phases each, counted as phases 0 to 11. In every machine cycle the block produces the address latch strobe, the active-low code read strobe, and the active-low data read and write strobes. It drives the shared low address/data byte with an output enable, and it drives the high address byte.

Two kinds of machine cycle exist. A fetch cycle has two halves, and each half carries one code byte. Those bytes come from external memory or from internal memory, depending on a code-select level that is latched during reset. A data cycle carries one external data read or write, with an 8-bit or 16-bit address. A data cycle emits only one of the two address latch pulses and none of the code read pulses. Bytes read from the shared bus are captured on the edge where the active read strobe returns high.

A reset request takes effect only after it has been held for two whole machine cycles. After reset the block starts again at phase 0 with a fetch cycle.

Top module: `xbus_strobe_gen`

## Requirements
- R1: In a fetch cycle `addr_latch_o` is high in phases 0-1 and 6-7, and low in every other phase.
- R2: In a fetch cycle with external code selected, `code_rd_no` is low in phases 3-5 and 9-11, and high in every other phase.
- R3: With internal code selected, `code_rd_no` stays high, `ad_oe_o` is low in fetch cycles, and `ah_o` equals `ah_latch_i`. `addr_latch_o` keeps the R1 cadence.
- R4: In a data cycle `code_rd_no` stays high. When `dwe_i` was 0 (read), `xrd_no` is low in phases 3-10. When `dwe_i` was 1 (write), `xwr_no` is low in phases 3-10. The other data strobe stays high.
- R5: `dreq_i`, `dwe_i`, `dwide_i`, `daddr_i` and `wdata_i` are sampled only on the edge that ends phase 11. A set `dreq_i` makes the next cycle a data cycle, and a clear one makes it a fetch cycle. A data cycle has its single address latch pulse in phases 0-1 and none in phases 6-7.
- R6: When the shared bus carries an address, `ad_oe_o` is high and `ad_o` is the low address byte (bits 7:0). This holds in phases 0-2 of each externally fetched half, and in phases 0-2 of a data cycle. It therefore stays stable for one phase after `addr_latch_o` falls. In a write cycle `ad_o` carries the write data in phases 3-11. At all other times `ad_oe_o` is low.
- R7: `ah_o` carries the high address byte (bits 15:8) during externally fetched cycles and during data cycles with `dwide_i`=1. It carries `ah_latch_i` during 8-bit data cycles and while in reset.
- R8: `ad_i` is captured on the clock edge where `code_rd_no` rises (end of phase 5 or 11) or where `xrd_no` rises (end of phase 10). In the following clock, `rdata_vld_o` is high for exactly one clock, with `rdata_o` holding the captured byte. `rdata_is_data_o` is 1 for a data read and 0 for a code byte.
- R9: `code_int_i` (1 = internal code, 0 = external) is latched only while in reset. Changes while running have no effect.
- R10: `rst_req_i` resets the block only after it has been high on 24 consecutive clock edges. Shorter pulses are ignored. While in reset, all strobes are inactive and `ad_oe_o` is low. On release the block starts at phase 0 with a fetch cycle.
- R11: The first half of a fetch cycle uses the `code_addr_i` sampled on the edge ending phase 11, or on the release edge after reset. The second half uses the value sampled on the edge ending phase 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| rst_req_i | input | 1 | Reset request, qualified over two machine cycles |
| code_int_i | input | 1 | Code select level, 1 = internal, latched in reset |
| code_addr_i | input | 16 | Code fetch address |
| dreq_i | input | 1 | External data access request for the next cycle |
| dwe_i | input | 1 | Data access direction, 1 = write |
| dwide_i | input | 1 | Data address width, 1 = 16-bit |
| daddr_i | input | 16 | Data address |
| wdata_i | input | 8 | Write data |
| ah_latch_i | input | 8 | High byte port latch value |
| ad_i | input | 8 | Shared bus input |
| addr_latch_o | output | 1 | Address latch strobe |
| code_rd_no | output | 1 | Code read strobe, active low |
| xrd_no | output | 1 | Data read strobe, active low |
| xwr_no | output | 1 | Data write strobe, active low |
| ad_o | output | 8 | Shared bus output value |
| ad_oe_o | output | 1 | Shared bus drive enable for all bits |
| ah_o | output | 8 | High address byte output |
| rdata_o | output | 8 | Captured byte |
| rdata_vld_o | output | 1 | One-clock capture pulse |
| rdata_is_data_o | output | 1 | Capture source, 1 = data read |

## Verification
The sequence is driven through every ordered pair of the five cycle kinds: fetch, 8-bit read, 16-bit read, 8-bit write and 16-bit write. Addresses, write data and bus input are random, and the whole sweep runs once with external and once with internal code selected. The pairs separate the effect of the previous cycle kind from that of the current one on strobes, bus drive and capture. The two code-select levels separate suppression of the code strobe from the address latch cadence. Reset requests of 23 and 24 edges distinguish the qualification threshold from an off-by-one error. Toggling the code select while running, and randomising the data inputs outside phase 11, show the inputs that must be ignored.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic {
    CYC_FETCH = 1'b0,
    CYC_DATA  = 1'b1
  } cyc_kind_e;
endpackage

// File: rtl/xbus_rst_qual.sv
module xbus_rst_qual #(
  parameter int LIM = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_req_i,
  input  logic code_int_i,
  output logic rst_act_o,
  output logic code_int_o
);
  localparam int CW = $clog2(LIM + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(LIM);
  localparam logic [CW-1:0] CNT_FIRE = CW'(LIM - 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;
  logic          cint_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      act_q  <= 1'b1;
      cint_q <= 1'b0;
    end else begin
      if (!rst_req_i)            cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CW'(1);
      // code select follows the pin only while reset is active
      if (act_q) cint_q <= code_int_i;
      if (!rst_req_i)              act_q <= 1'b0;
      else if (cnt_q == CNT_FIRE)  act_q <= 1'b1;
    end
  end

  assign rst_act_o  = act_q;
  assign code_int_o = cint_q;
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int CYC_LEN = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       rst_act_i,
  input  logic [AW-1:0]              code_addr_i,
  input  logic                       dreq_i,
  input  logic                       dwe_i,
  input  logic                       dwide_i,
  input  logic [AW-1:0]              daddr_i,
  input  logic [DW-1:0]              wdata_i,
  output logic [$clog2(CYC_LEN)-1:0] phase_o,
  output cyc_kind_e                  kind_o,
  output logic [AW-1:0]              faddr_o,
  output logic [AW-1:0]              daddr_o,
  output logic                       dwe_o,
  output logic                       dwide_o,
  output logic [DW-1:0]              wdata_o
);
  localparam int PW = $clog2(CYC_LEN);
  localparam logic [PW-1:0] PH_LAST = PW'(CYC_LEN - 1);
  localparam logic [PW-1:0] PH_MID  = PW'(CYC_LEN / 2 - 1);

  logic [PW-1:0] phase_q;
  cyc_kind_e     kind_q;
  logic [AW-1:0] faddr_q, daddr_q;
  logic          dwe_q, dwide_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      kind_q  <= CYC_FETCH;
      faddr_q <= '0;
      daddr_q <= '0;
      dwe_q   <= 1'b0;
      dwide_q <= 1'b0;
      wdata_q <= '0;
    end else if (rst_act_i) begin
      phase_q <= '0;
      kind_q  <= CYC_FETCH;
      faddr_q <= code_addr_i;
      daddr_q <= '0;
      dwe_q   <= 1'b0;
      dwide_q <= 1'b0;
      wdata_q <= '0;
    end else begin
      phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + PW'(1);
      if (phase_q == PH_LAST) begin
        kind_q  <= dreq_i ? CYC_DATA : CYC_FETCH;
        daddr_q <= daddr_i;
        dwe_q   <= dwe_i;
        dwide_q <= dwide_i;
        wdata_q <= wdata_i;
        faddr_q <= code_addr_i;
      end else if (phase_q == PH_MID) begin
        faddr_q <= code_addr_i;
      end
    end
  end

  assign phase_o = phase_q;
  assign kind_o  = kind_q;
  assign faddr_o = faddr_q;
  assign daddr_o = daddr_q;
  assign dwe_o   = dwe_q;
  assign dwide_o = dwide_q;
  assign wdata_o = wdata_q;
endmodule

// File: rtl/xbus_dec.sv
module xbus_dec
  import xbus_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int CYC_LEN   = 12,
  parameter int PH_PER_ST = 2
) (
  input  logic [$clog2(CYC_LEN)-1:0] phase_i,
  input  cyc_kind_e                  kind_i,
  input  logic                       rst_act_i,
  input  logic                       code_int_i,
  input  logic [AW-1:0]              faddr_i,
  input  logic [AW-1:0]              daddr_i,
  input  logic                       dwe_i,
  input  logic                       dwide_i,
  input  logic [DW-1:0]              wdata_i,
  input  logic [DW-1:0]              ah_latch_i,
  output logic                       ale_o,
  output logic                       code_rd_no,
  output logic                       xrd_no,
  output logic                       xwr_no,
  output logic [DW-1:0]              ad_o,
  output logic                       ad_oe_o,
  output logic [DW-1:0]              ah_o,
  output logic                       cap_o,
  output logic                       cap_data_o
);
  localparam int PW   = $clog2(CYC_LEN);
  localparam int HALF = CYC_LEN / 2;
  localparam logic [PW-1:0] HALF_P    = PW'(HALF);
  localparam logic [PW-1:0] HALF_LAST = PW'(HALF - 1);
  localparam logic [PW-1:0] ALE_END   = PW'(PH_PER_ST);
  localparam logic [PW-1:0] ADDR_END  = PW'(PH_PER_ST);
  localparam logic [PW-1:0] STB_BEG   = PW'(HALF / 2);
  localparam logic [PW-1:0] DSTB_END  = PW'(CYC_LEN - 2);

  logic          hi_half;
  logic [PW-1:0] q;

  assign hi_half = phase_i >= HALF_P;
  assign q       = hi_half ? phase_i - HALF_P : phase_i;

  always_comb begin
    ale_o      = 1'b0;
    code_rd_no = 1'b1;
    xrd_no     = 1'b1;
    xwr_no     = 1'b1;
    ad_o       = '0;
    ad_oe_o    = 1'b0;
    ah_o       = ah_latch_i;
    cap_o      = 1'b0;
    cap_data_o = 1'b0;
    if (!rst_act_i) begin
      unique case (kind_i)
        CYC_FETCH: begin
          ale_o = q < ALE_END;
          if (!code_int_i) begin
            ah_o = faddr_i[AW-1:DW];
            if (q <= ADDR_END) begin
              ad_oe_o = 1'b1;
              ad_o    = faddr_i[DW-1:0];
            end
            if (q >= STB_BEG) code_rd_no = 1'b0;
            cap_o = q == HALF_LAST;
          end
        end
        CYC_DATA: begin
          // second latch pulse and both code pulses are dropped
          ale_o = phase_i < ALE_END;
          if (dwide_i) ah_o = daddr_i[AW-1:DW];
          if (phase_i <= ADDR_END) begin
            ad_oe_o = 1'b1;
            ad_o    = daddr_i[DW-1:0];
          end else if (dwe_i) begin
            ad_oe_o = 1'b1;
            ad_o    = wdata_i;
          end
          if (phase_i >= STB_BEG && phase_i <= DSTB_END) begin
            if (dwe_i) xwr_no = 1'b0;
            else       xrd_no = 1'b0;
          end
          cap_o      = !dwe_i && (phase_i == DSTB_END);
          cap_data_o = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/xbus_cap.sv
module xbus_cap #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic          cap_data_i,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] rdata_o,
  output logic          vld_o,
  output logic          is_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o   <= '0;
      vld_o     <= 1'b0;
      is_data_o <= 1'b0;
    end else begin
      vld_o <= cap_i;
      if (cap_i) begin
        rdata_o   <= ad_i;
        is_data_o <= cap_data_i;
      end
    end
  end
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
  import xbus_pkg::*;
#(
  parameter int DW        = 8,
  parameter int STATES    = 6,
  parameter int PH_PER_ST = 2,
  parameter int RST_MCYC  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rst_req_i,
  input  logic            code_int_i,
  input  logic [2*DW-1:0] code_addr_i,
  input  logic            dreq_i,
  input  logic            dwe_i,
  input  logic            dwide_i,
  input  logic [2*DW-1:0] daddr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW-1:0]   ah_latch_i,
  input  logic [DW-1:0]   ad_i,
  output logic            addr_latch_o,
  output logic            code_rd_no,
  output logic            xrd_no,
  output logic            xwr_no,
  output logic [DW-1:0]   ad_o,
  output logic            ad_oe_o,
  output logic [DW-1:0]   ah_o,
  output logic [DW-1:0]   rdata_o,
  output logic            rdata_vld_o,
  output logic            rdata_is_data_o
);
  localparam int AW      = 2 * DW;
  localparam int CYC_LEN = STATES * PH_PER_ST;
  localparam int RST_LIM = RST_MCYC * CYC_LEN;
  localparam int PW      = $clog2(CYC_LEN);

  logic          rst_act, code_int_q;
  logic [PW-1:0] phase;
  cyc_kind_e     kind;
  logic [AW-1:0] faddr, daddr_q;
  logic          dwe_q, dwide_q;
  logic [DW-1:0] wdata_q;
  logic          cap, cap_data;

  xbus_rst_qual #(.LIM(RST_LIM)) i_rst_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_req_i  (rst_req_i),
    .code_int_i (code_int_i),
    .rst_act_o  (rst_act),
    .code_int_o (code_int_q)
  );

  xbus_seq #(.AW(AW), .DW(DW), .CYC_LEN(CYC_LEN)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_act_i   (rst_act),
    .code_addr_i (code_addr_i),
    .dreq_i      (dreq_i),
    .dwe_i       (dwe_i),
    .dwide_i     (dwide_i),
    .daddr_i     (daddr_i),
    .wdata_i     (wdata_i),
    .phase_o     (phase),
    .kind_o      (kind),
    .faddr_o     (faddr),
    .daddr_o     (daddr_q),
    .dwe_o       (dwe_q),
    .dwide_o     (dwide_q),
    .wdata_o     (wdata_q)
  );

  xbus_dec #(.AW(AW), .DW(DW), .CYC_LEN(CYC_LEN), .PH_PER_ST(PH_PER_ST)) i_dec (
    .phase_i    (phase),
    .kind_i     (kind),
    .rst_act_i  (rst_act),
    .code_int_i (code_int_q),
    .faddr_i    (faddr),
    .daddr_i    (daddr_q),
    .dwe_i      (dwe_q),
    .dwide_i    (dwide_q),
    .wdata_i    (wdata_q),
    .ah_latch_i (ah_latch_i),
    .ale_o      (addr_latch_o),
    .code_rd_no (code_rd_no),
    .xrd_no     (xrd_no),
    .xwr_no     (xwr_no),
    .ad_o       (ad_o),
    .ad_oe_o    (ad_oe_o),
    .ah_o       (ah_o),
    .cap_o      (cap),
    .cap_data_o (cap_data)
  );

  xbus_cap #(.DW(DW)) i_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (cap),
    .cap_data_i (cap_data),
    .ad_i       (ad_i),
    .rdata_o    (rdata_o),
    .vld_o      (rdata_vld_o),
    .is_data_o  (rdata_is_data_o)
  );
endmodule

// File: rtl/xbus_strobe_gen_chk.sv
module xbus_strobe_gen_chk #(
  parameter int DW  = 8,
  parameter int LIM = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rst_req_i,
  input logic          rst_act,
  input logic          code_int_q,
  input logic          addr_latch_o,
  input logic          code_rd_no,
  input logic          xrd_no,
  input logic          xwr_no,
  input logic [DW-1:0] ad_o,
  input logic          ad_oe_o,
  input logic          rdata_vld_o,
  input logic          rdata_is_data_o
);
  localparam int CW = $clog2(LIM + 1);
  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                hi_cnt <= '0;
    else if (!rst_req_i)        hi_cnt <= '0;
    else if (hi_cnt != CW'(LIM)) hi_cnt <= hi_cnt + CW'(1);
  end

  a_r1_latch_width: assert property (@(posedge clk_i) disable iff (!rst_ni || rst_act)
    $rose(addr_latch_o) |=> addr_latch_o);
  a_r3_no_code_rd_internal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_int_q |-> code_rd_no);
  a_r4_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~code_rd_no, ~xrd_no, ~xwr_no}) <= 1);
  a_r4_write_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xwr_no |-> ad_oe_o);
  a_r6_latch_before_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_latch_o |-> (code_rd_no && xrd_no && xwr_no));
  a_r6_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni || rst_act)
    ($fell(addr_latch_o) && !code_int_q) |-> (ad_oe_o && $stable(ad_o)));
  a_r8_float_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xrd_no || !code_rd_no) |-> !ad_oe_o);
  a_r8_code_capture: assert property (@(posedge clk_i) disable iff (!rst_ni || rst_act)
    $rose(code_rd_no) |-> (rdata_vld_o && !rdata_is_data_o));
  a_r8_data_capture: assert property (@(posedge clk_i) disable iff (!rst_ni || rst_act)
    $rose(xrd_no) |-> (rdata_vld_o && rdata_is_data_o));
  a_r10_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_act) |-> (hi_cnt >= CW'(LIM)));
  a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_act |-> (!addr_latch_o && code_rd_no && xrd_no && xwr_no && !ad_oe_o));
endmodule

bind xbus_strobe_gen xbus_strobe_gen_chk #(.DW(DW), .LIM(RST_LIM)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .rst_req_i       (rst_req_i),
  .rst_act         (rst_act),
  .code_int_q      (code_int_q),
  .addr_latch_o    (addr_latch_o),
  .code_rd_no      (code_rd_no),
  .xrd_no          (xrd_no),
  .xwr_no          (xwr_no),
  .ad_o            (ad_o),
  .ad_oe_o         (ad_oe_o),
  .rdata_vld_o     (rdata_vld_o),
  .rdata_is_data_o (rdata_is_data_o)
);

// File: tb/test_xbus_strobe_gen.sv
module test_xbus_strobe_gen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0, rst_req_i = 1'b0, code_int_i = 1'b0;
  logic [15:0] code_addr_i = '0, daddr_i = '0;
  logic        dreq_i = 1'b0, dwe_i = 1'b0, dwide_i = 1'b0;
  logic [7:0]  wdata_i = '0, ah_latch_i = '0, ad_i = '0;
  logic        addr_latch_o, code_rd_no, xrd_no, xwr_no, ad_oe_o;
  logic [7:0]  ad_o, ah_o, rdata_o;
  logic        rdata_vld_o, rdata_is_data_o;

  always #4 clk = ~clk;

  xbus_strobe_gen i_xbus_strobe_gen (
    .clk_i(clk), .rst_ni(rst_ni), .rst_req_i(rst_req_i), .code_int_i(code_int_i),
    .code_addr_i(code_addr_i), .dreq_i(dreq_i), .dwe_i(dwe_i), .dwide_i(dwide_i),
    .daddr_i(daddr_i), .wdata_i(wdata_i), .ah_latch_i(ah_latch_i), .ad_i(ad_i),
    .addr_latch_o(addr_latch_o), .code_rd_no(code_rd_no), .xrd_no(xrd_no),
    .xwr_no(xwr_no), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ah_o(ah_o),
    .rdata_o(rdata_o), .rdata_vld_o(rdata_vld_o), .rdata_is_data_o(rdata_is_data_o)
  );

  int n_cmp = 0, n_bad = 0;
  // bench model
  int          ph = 0, hcnt = 0, sched = 0;
  bit          kind = 0, m_we = 0, m_wide = 0, cint = 0, in_rst = 1;
  logic [15:0] m_daddr = '0, faddr = '0;
  logic [7:0]  m_wdata = '0, exp_rd = '0;
  bit          exp_vld = 0, exp_isd = 0;
  bit          por_n = 0, want_req = 0, cint_v = 0, sweeping = 0, ea_probe = 0;
  bit          done = 0;

  task automatic chk(input string tag, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    int q;
    bit e_ale, e_psen, e_rd, e_wr, e_oe;
    logic [7:0] e_ad, e_ah;
    string ptag, atag;
    q = ph % 6;
    e_ale = 0; e_psen = 1; e_rd = 1; e_wr = 1; e_oe = 0; e_ad = '0; e_ah = ah_latch_i;
    ptag = ea_probe ? "R9" : (cint ? "R3" : "R2");
    atag = "R1";
    if (!in_rst) begin
      if (!kind) begin
        e_ale = q < 2;
        if (!cint) begin
          e_psen = !(q >= 3);
          e_oe = q < 3;
          e_ad = faddr[7:0];
          e_ah = faddr[15:8];
        end
      end else begin
        atag = "R5";               // single latch pulse in a data cycle
        e_ale = ph < 2;
        e_rd = !(!m_we && ph >= 3 && ph <= 10);
        e_wr = !(m_we && ph >= 3 && ph <= 10);
        e_oe = (ph < 3) || m_we;
        e_ad = (ph < 3) ? m_daddr[7:0] : m_wdata;
        if (m_wide) e_ah = m_daddr[15:8];
      end
    end
    if (in_rst) begin
      chk("R10", "idle latch", 16'(addr_latch_o), 16'(e_ale));
      chk("R10", "idle strobes", {13'd0, code_rd_no, xrd_no, xwr_no}, 16'h7);
      chk("R10", "idle drive", 16'(ad_oe_o), 16'h0);
    end else begin
      chk(atag, "addr latch", 16'(addr_latch_o), 16'(e_ale));
      chk(ptag, "code rd", 16'(code_rd_no), 16'(e_psen));
      chk("R4", "data rd/wr", {14'd0, xrd_no, xwr_no}, {14'd0, e_rd, e_wr});
      chk("R6", "bus oe", 16'(ad_oe_o), 16'(e_oe));
      if (e_oe) chk(kind ? "R6" : "R11", "bus value", 16'(ad_o), 16'(e_ad));
    end
    chk("R7", "high byte", 16'(ah_o), 16'(e_ah));
    chk("R8", "capture valid", 16'(rdata_vld_o), 16'(exp_vld));
    if (exp_vld) chk("R8", "capture data", {7'd0, rdata_is_data_o, rdata_o},
                     {7'd0, exp_isd, exp_rd});
  endtask

  task automatic step();
    bit cap, capd;
    int t, pr;
    @(negedge clk);
    check_outputs();
    cap = 0; capd = 0;
    if (!in_rst) begin
      if (!kind && !cint && (ph % 6) == 5) cap = 1;
      if (kind && !m_we && ph == 10) begin cap = 1; capd = 1; end
    end
    // R5: data inputs randomised every clock, only phase 11 counts
    code_addr_i = 16'($urandom); ad_i = 8'($urandom); ah_latch_i = 8'($urandom);
    daddr_i = 16'($urandom); wdata_i = 8'($urandom);
    dreq_i = 1'($urandom); dwe_i = 1'($urandom); dwide_i = 1'($urandom);
    if (!in_rst && ph == 11) begin
      t = 0;
      if (sweeping && sched < 50) begin
        pr = sched / 2;
        t = (sched % 2 == 0) ? pr / 5 : pr % 5;
        sched++;
      end
      dreq_i = t != 0; dwe_i = t >= 3; dwide_i = (t == 2) || (t == 4);
    end
    rst_req_i = want_req; code_int_i = cint_v; rst_ni = por_n;
    exp_vld = cap; if (cap) begin exp_rd = ad_i; exp_isd = capd; end
    hcnt = want_req ? hcnt + 1 : 0;
    if (in_rst) begin
      if (!want_req && por_n) begin
        in_rst = 0; ph = 0; kind = 0; faddr = code_addr_i; cint = cint_v;
      end
    end else begin
      if (ph == 11) begin
        kind = dreq_i; m_we = dwe_i; m_wide = dwide_i; m_daddr = daddr_i;
        m_wdata = wdata_i; faddr = code_addr_i;
      end else if (ph == 5) faddr = code_addr_i;
      ph = (ph + 1) % 12;
      if (hcnt >= 24) in_rst = 1;   // R10 qualification threshold
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();                         // R10 power-on idle
    por_n = 1; sweeping = 1; sched = 0;
    step();
    repeat (12 * 52) step();                   // external code, all cycle pairs
    ea_probe = 1; cint_v = 1;                  // R9: pin change while running
    repeat (36) step();
    ea_probe = 0;
    want_req = 1; repeat (23) step();          // R10: 23 edges, ignored
    want_req = 0; repeat (24) step();
    want_req = 1; repeat (30) step();          // R10: qualified, latches internal
    want_req = 0; sched = 0;
    step();
    repeat (12 * 52) step();                   // internal code, all cycle pairs
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule